// File: doc/BRIEF.md
# Alternating dual-output PWM generator

This block produces fixed-frequency pulse-width-modulated drive on two outputs that take turns. A digital sawtooth oscillator runs a rise phase and a discharge phase, each with its own programmable length in clock cycles. The discharge phase is presented as a clock output and serves as dead time: both drive outputs are held low throughout it. When discharge ends, the output whose turn it is goes high. The next period belongs to the other output, so each output runs at half the oscillator rate and its duty stays below one half.

A pulse ends at whichever comes first of three events: the ramp reaches the control level, the current-limit flag is raised, or the overcurrent flag is raised. The ramp is either the oscillator's own rise count (voltage-mode) or an external ramp word (current-mode). A fixed offset, equal to the ramp valley, is added to the ramp before the comparison. A blanking counter hides the ramp comparison and the current-limit flag for a programmable number of cycles after each pulse starts. The overcurrent flag is never hidden. The enable input stops everything and resets the output steering.

Top module: `altpwm_gen`

## Requirements
- R1: `clk_out` is high for `fall_len` cycles (discharge) and then low for `rise_len` cycles (rise), repeating. It is high during reset and while disabled, and a length of 0 acts as 1.
- R2: `out_a` and `out_b` are both low in every cycle in which `clk_out` is high.
- R3: A pulse begins in the first rise cycle, which is the cycle in which `clk_out` has just fallen. The first pulse after reset or enable goes to `out_a`, and the output used alternates every oscillator period.
- R4: `out_a` and `out_b` are never high in the same cycle.
- R5: Number the rise cycles k = 0, 1, and so on. In rise cycle k the ramp is k when `ramp_sel`=0 and `ext_ramp` when `ramp_sel`=1. The pulse is low from the cycle after the first unblanked cycle in which ramp + OFFSET >= `ctrl`. OFFSET defaults to 16.
- R6: When `ctrl` <= OFFSET at the end of discharge, no pulse is produced in that period.
- R7: In rise cycles k < `blank_len`, the ramp comparison and `cur_lim` have no effect on the pulse.
- R8: In an unblanked rise cycle, `cur_lim` high makes the pulse low from the next cycle.
- R9: `over_cur` high in any rise cycle, blanked or not, makes the pulse low from the next cycle.
- R10: A terminated pulse stays low until the next end of discharge, even if the terminating condition goes away.
- R11: One cycle after `en` is sampled low, both outputs are low and `clk_out` is high. After `en` returns high, the oscillator restarts at the beginning of discharge and `out_a` fires first.
- R12: A pulse with no termination lasts exactly `rise_len` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces outputs low and resets steering |
| rise_len | input | W | Rise phase length in cycles |
| fall_len | input | W | Discharge (dead time) length in cycles |
| blank_len | input | W | Leading-edge blanking length in cycles |
| ctrl | input | W | Control level for the ramp comparison |
| ramp_sel | input | 1 | 0: internal rise count; 1: external ramp |
| ext_ramp | input | W | External ramp sample |
| cur_lim | input | 1 | Current-limit flag (blankable) |
| over_cur | input | 1 | Overcurrent flag (never blanked) |
| out_a | output | 1 | Drive output A |
| out_b | output | 1 | Drive output B |
| clk_out | output | 1 | Registered oscillator clock, high during discharge |

## Verification
The hardest cases to reach are flags that arrive at a chosen rise cycle and then go away. Examples are an overcurrent pulse inside the blanking window, or a current-limit pulse that is over before blanking ends. The bench counts negative edges from the release of reset. This lets it raise and drop `over_cur` and `cur_lim` in a known rise cycle k, then measure each output's pulse width over two full periods. The steering reset is reached by dropping enable while `out_b` is mid-pulse and checking that `out_a` leads after the restart.

// File: rtl/altpwm_pkg.sv
package altpwm_pkg;
  typedef enum logic {
    PH_FALL = 1'b0,
    PH_RISE = 1'b1
  } osc_phase_e;
endpackage

// File: rtl/altpwm_osc.sv
module altpwm_osc
  import altpwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] rise_len,
  input  logic [W-1:0] fall_len,
  output logic [W-1:0] ramp_cnt,
  output logic         clk_q,
  output logic         cyc_start,
  output logic         rise_end
);
  localparam int CW = W + 1;

  osc_phase_e   ph;
  logic [W-1:0] cnt;
  logic [CW-1:0] cnt_inc;
  logic [CW-1:0] len_now;
  logic          last;

  assign cnt_inc = {1'b0, cnt} + CW'(1);
  assign len_now = (ph == PH_FALL) ? {1'b0, fall_len} : {1'b0, rise_len};
  assign last    = (cnt_inc >= len_now);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      ph  <= PH_FALL;
      cnt <= '0;
    end else if (last) begin
      ph  <= (ph == PH_FALL) ? PH_RISE : PH_FALL;
      cnt <= '0;
    end else begin
      cnt <= cnt_inc[W-1:0];
    end
  end

  assign ramp_cnt  = (ph == PH_RISE) ? cnt : '0;
  assign clk_q     = (ph == PH_FALL);
  assign cyc_start = en && last && (ph == PH_FALL);
  assign rise_end  = en && last && (ph == PH_RISE);
endmodule

// File: rtl/altpwm_blank.sv
module altpwm_blank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         load,
  input  logic [W-1:0] blank_len,
  output logic         blanked
);
  logic [W-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      bcnt <= '0;
    end else if (load) begin
      bcnt <= blank_len;
    end else if (bcnt != '0) begin
      bcnt <= bcnt - W'(1);
    end
  end

  assign blanked = (bcnt != '0);
endmodule

// File: rtl/altpwm_steer.sv
module altpwm_steer #(
  parameter int W      = 8,
  parameter int OFFSET = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         cyc_start,
  input  logic         rise_end,
  input  logic         blanked,
  input  logic [W-1:0] ramp_val,
  input  logic [W-1:0] ctrl,
  input  logic         cur_lim,
  input  logic         over_cur,
  output logic         out_a,
  output logic         out_b
);
  localparam int CW = W + 1;
  localparam logic [CW-1:0] OFS = CW'(OFFSET);

  logic          nxt_b;
  logic          cmp_hit;
  logic          open_ok;
  logic          kill;

  assign cmp_hit = (({1'b0, ramp_val} + OFS) >= {1'b0, ctrl});
  assign open_ok = ({1'b0, ctrl} > OFS);
  assign kill    = over_cur || (!blanked && (cur_lim || cmp_hit));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      nxt_b <= 1'b0;
      out_a <= 1'b0;
      out_b <= 1'b0;
    end else if (cyc_start) begin
      nxt_b <= ~nxt_b;
      out_a <= open_ok && !nxt_b;
      out_b <= open_ok && nxt_b;
    end else if (rise_end || kill) begin
      out_a <= 1'b0;
      out_b <= 1'b0;
    end
  end
endmodule

// File: rtl/altpwm_gen.sv
module altpwm_gen #(
  parameter int W      = 8,
  parameter int OFFSET = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] rise_len,
  input  logic [W-1:0] fall_len,
  input  logic [W-1:0] blank_len,
  input  logic [W-1:0] ctrl,
  input  logic         ramp_sel,
  input  logic [W-1:0] ext_ramp,
  input  logic         cur_lim,
  input  logic         over_cur,
  output logic         out_a,
  output logic         out_b,
  output logic         clk_out
);
  logic [W-1:0] ramp_cnt;
  logic [W-1:0] ramp_val;
  logic         cyc_start;
  logic         rise_end;
  logic         blanked;

  altpwm_osc #(.W(W)) u_osc (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .rise_len  (rise_len),
    .fall_len  (fall_len),
    .ramp_cnt  (ramp_cnt),
    .clk_q     (clk_out),
    .cyc_start (cyc_start),
    .rise_end  (rise_end)
  );

  altpwm_blank #(.W(W)) u_blank (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .load      (cyc_start),
    .blank_len (blank_len),
    .blanked   (blanked)
  );

  assign ramp_val = ramp_sel ? ext_ramp : ramp_cnt;

  altpwm_steer #(.W(W), .OFFSET(OFFSET)) u_steer (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .cyc_start (cyc_start),
    .rise_end  (rise_end),
    .blanked   (blanked),
    .ramp_val  (ramp_val),
    .ctrl      (ctrl),
    .cur_lim   (cur_lim),
    .over_cur  (over_cur),
    .out_a     (out_a),
    .out_b     (out_b)
  );
endmodule

// File: rtl/altpwm_gen_chk.sv
module altpwm_gen_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic over_cur,
  input logic out_a,
  input logic out_b,
  input logic clk_out
);
  // R4
  excl_out_chk: assert property (@(posedge clk) disable iff (rst)
    !(out_a && out_b));

  // R2
  dead_time_chk: assert property (@(posedge clk) disable iff (rst)
    clk_out |-> (!out_a && !out_b));

  // R3
  start_a_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_a) |-> $fell(clk_out));

  // R3
  start_b_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_b) |-> $fell(clk_out));

  // R11
  dis_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!out_a && !out_b && clk_out));

  // R9
  oc_kill_chk: assert property (@(posedge clk) disable iff (rst)
    (over_cur && (out_a || out_b)) |=> (!out_a && !out_b));

  // R10
  no_restart_a_chk: assert property (@(posedge clk) disable iff (rst)
    !out_a |=> (!out_a || $fell(clk_out)));

  // R10
  no_restart_b_chk: assert property (@(posedge clk) disable iff (rst)
    !out_b |=> (!out_b || $fell(clk_out)));
endmodule

bind altpwm_gen altpwm_gen_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .over_cur (over_cur),
  .out_a    (out_a),
  .out_b    (out_b),
  .clk_out  (clk_out)
);

// File: tb/sim_altpwm_gen.sv
module sim_altpwm_gen;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic [W-1:0] rise_len = 8'd20;
  logic [W-1:0] fall_len = 8'd4;
  logic [W-1:0] blank_len = 8'd0;
  logic [W-1:0] ctrl = 8'd0;
  logic         ramp_sel = 1'b0;
  logic [W-1:0] ext_ramp = 8'd0;
  logic         cur_lim = 1'b0;
  logic         over_cur = 1'b0;
  logic         out_a, out_b, clk_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  altpwm_gen #(.W(W), .OFFSET(16)) u0 (
    .clk(clk), .rst(rst), .en(en), .rise_len(rise_len), .fall_len(fall_len),
    .blank_len(blank_len), .ctrl(ctrl), .ramp_sel(ramp_sel), .ext_ramp(ext_ramp),
    .cur_lim(cur_lim), .over_cur(over_cur), .out_a(out_a), .out_b(out_b),
    .clk_out(clk_out)
  );

  always #10 clk = ~clk;

  typedef struct packed {
    logic [7:0] ctrl;
    logic       sel;
    logic [7:0] ext;
    logic [7:0] rise;
    logic [7:0] fall;
    logic [7:0] blank;
    logic [7:0] wid;
  } vec_t;

  // Expected width per output = first unblanked k with ramp+16 >= ctrl, plus one, capped at rise.
  localparam vec_t VT [8] = '{
    '{8'd26,  1'b0, 8'd0,  8'd20, 8'd4, 8'd2, 8'd11}, // R5 compare at k=10
    '{8'd16,  1'b0, 8'd0,  8'd20, 8'd4, 8'd2, 8'd0},  // R6 ctrl equals offset
    '{8'd17,  1'b0, 8'd0,  8'd20, 8'd4, 8'd0, 8'd2},  // R5 smallest open level
    '{8'd17,  1'b0, 8'd0,  8'd20, 8'd4, 8'd5, 8'd6},  // R7 compare held off by blanking
    '{8'd200, 1'b0, 8'd0,  8'd20, 8'd4, 8'd2, 8'd20}, // R12 no termination
    '{8'd60,  1'b1, 8'd50, 8'd20, 8'd4, 8'd3, 8'd4},  // R5 external ramp above level
    '{8'd60,  1'b1, 8'd10, 8'd12, 8'd3, 8'd0, 8'd12}, // R12 external ramp below level
    '{8'd20,  1'b0, 8'd0,  8'd8,  8'd2, 8'd1, 8'd5}   // R1 short period
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic start_run(input logic [7:0] c, input logic s, input logic [7:0] x,
                           input logic [7:0] r, input logic [7:0] f, input logic [7:0] b);
    @(negedge clk);
    rst = 1'b1; en = 1'b1;
    ctrl = c; ramp_sel = s; ext_ramp = x; rise_len = r; fall_len = f; blank_len = b;
    cur_lim = 1'b0; over_cur = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic measure(input int per, output int na, output int nb,
                         output int ord, output int nclk);
    na = 0; nb = 0; ord = 0; nclk = 0;
    for (int i = 0; i < 2 * per; i++) begin
      if (out_a) begin na++; if (i >= per) ord++; end
      if (out_b) begin nb++; if (i < per) ord++; end
      if (clk_out) nclk++;
      @(negedge clk);
    end
  endtask

  initial begin
    int na, nb, ord, nclk, per;
    // R1 R2 reset state
    repeat (3) @(negedge clk);
    chk(out_a == 1'b0 && out_b == 1'b0, "R2 reset outputs", {out_a, out_b}, 0);
    chk(clk_out == 1'b1, "R1 reset clk_out", clk_out, 1);

    for (int v = 0; v < 8; v++) begin
      start_run(VT[v].ctrl, VT[v].sel, VT[v].ext, VT[v].rise, VT[v].fall, VT[v].blank);
      per = int'(VT[v].rise) + int'(VT[v].fall);
      measure(per, na, nb, ord, nclk);
      chk(na == int'(VT[v].wid), $sformatf("R5 R6 R12 vec%0d width A", v), na, VT[v].wid);
      chk(nb == int'(VT[v].wid), $sformatf("R5 R6 R12 vec%0d width B", v), nb, VT[v].wid);
      chk(ord == 0, $sformatf("R3 vec%0d A leads B", v), ord, 0);
      chk(nclk == 2 * int'(VT[v].fall), $sformatf("R1 vec%0d clk_out high count", v),
          nclk, 2 * VT[v].fall);
    end

    // R9 R10: overcurrent in blanked k=2, dropped next cycle
    start_run(8'd200, 1'b0, 8'd0, 8'd20, 8'd4, 8'd10);
    na = 0; nb = 0;
    for (int i = 0; i < 48; i++) begin
      if (out_a) na++;
      if (out_b) nb++;
      if (i == 6) over_cur = 1'b1;
      if (i == 7) over_cur = 1'b0;
      @(negedge clk);
    end
    chk(na == 3, "R9 R10 overcurrent width A", na, 3);
    chk(nb == 20, "R9 width B after single fault", nb, 20);

    // R8: current limit held, blank 5
    start_run(8'd200, 1'b0, 8'd0, 8'd20, 8'd4, 8'd5);
    cur_lim = 1'b1;
    measure(24, na, nb, ord, nclk);
    chk(na == 6, "R8 current limit width A", na, 6);
    chk(nb == 6, "R8 current limit width B", nb, 6);

    // R7: current limit only inside blanking window
    start_run(8'd200, 1'b0, 8'd0, 8'd20, 8'd4, 8'd5);
    na = 0;
    for (int i = 0; i < 24; i++) begin
      if (out_a) na++;
      if (i == 4) cur_lim = 1'b1;
      if (i == 8) cur_lim = 1'b0;
      @(negedge clk);
    end
    chk(na == 20, "R7 blanked current limit ignored", na, 20);

    // R11: disable during B pulse, then A must lead
    start_run(8'd26, 1'b0, 8'd0, 8'd20, 8'd4, 8'd2);
    repeat (30) @(negedge clk);
    chk(out_b == 1'b1, "R3 B active in second period", out_b, 1);
    en = 1'b0;
    @(negedge clk);
    chk(out_a == 1'b0 && out_b == 1'b0, "R11 outputs low after disable", {out_a, out_b}, 0);
    chk(clk_out == 1'b1, "R11 clk_out high when disabled", clk_out, 1);
    repeat (3) @(negedge clk);
    chk(out_b == 1'b0, "R11 stays low while disabled", out_b, 0);
    en = 1'b1;
    measure(24, na, nb, ord, nclk);
    chk(na == 11 && ord == 0, "R11 A leads after enable", na, 11);
    chk(nb == 11, "R11 B width after enable", nb, 11);

    // R1: mid-run reset returns to reset state
    start_run(8'd200, 1'b0, 8'd0, 8'd20, 8'd4, 8'd0);
    repeat (8) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(out_a == 1'b0 && clk_out == 1'b1, "R1 reset mid pulse", {out_a, clk_out}, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule